// File: doc/BRIEF.md
# Interleaved Memory Bank Decoder

This block builds one large byte-addressable memory out of a row of smaller, equally sized RAM banks. It cuts each incoming flat byte address into two fields: a bank select and an offset inside that bank. The bank select is turned into a one-hot chip enable, and the offset and write data go to every bank. Read data comes back from the bank that was selected, through a multiplexer.

A build-time parameter picks where the bank select sits in the address. With high-order mapping the bank select comes from the most significant bits, so each bank holds one contiguous slice of the address space. With low-order mapping the bank select comes from the least significant bits, so consecutive bytes go to different banks in turn. The default build has sixteen banks of 2048 bytes, which gives a 32768-byte space addressed by 15 bits.

Requests enter on a valid/ready channel. Read responses leave on a second valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is taken in that same cycle. A response stays on the output, unchanged, until `rsp_ready` takes it.

Top module: `ilv_bank_mem`

## Requirements
- R1: After reset, `rsp_valid` is low and all chip enables are low while no request is presented.
- R2: With high-order mapping, the bank is address bits [14:11] and the offset is bits [10:0].
- R3: With low-order mapping, the bank is address bits [3:0] and the offset is bits [14:4].
- R4: In a cycle where a request is accepted, exactly one chip enable is high: bit n of `bank_en` for bank n. In every other cycle, all chip enables are low.
- R5: An accepted write changes only the addressed byte of the enabled bank. The same offset in every other bank keeps its value.
- R6: An accepted read raises `rsp_valid` on the next clock edge, and `rsp_rdata` then holds the byte last written to that address.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` and all chip enables are low, and `rsp_valid` and `rsp_rdata` do not change.
- R8: With low-order mapping, consecutive addresses map to different banks. With high-order mapping, consecutive addresses inside one 2048-byte block map to the same bank.
- R9: An accepted write produces no response: `rsp_valid` is low after it, unless a read is accepted.
- R10: Address 0 maps to bank 0, offset 0 in both mappings. Address 0x7FFF maps to bank 15 with offset 0x7FF (high-order mapping) or offset 0x7FF (low-order mapping), and both addresses store and return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_write | input | 1 | 1 means write, 0 means read |
| req_addr | input | 15 | Flat byte address |
| req_wdata | input | 8 | Write byte |
| bank_en | output | 16 | One-hot chip enable, bit n for bank n |
| bank_offset | output | 11 | Offset field sent to every bank |
| rsp_valid | output | 1 | A read result is waiting |
| rsp_ready | input | 1 | The consumer takes the read result |
| rsp_rdata | output | 8 | Read byte |

## Verification
The hardest case to reach is a read result that is held back while new requests keep coming. In that case, the chip enables and the offset path must stay quiet even though the address lines keep changing. The bench holds `rsp_ready` low for several cycles with a different request presented on each cycle, and then releases it in the same cycle as the next read. This covers both a stall and a take-and-accept cycle. A second hard case is proving that a write did not reach the wrong bank. To do this, the bench fills the same offset in all sixteen banks with distinct bytes, under both mappings, and reads every one back. Two instances, one for each mapping, receive the same stimulus and are compared against one behavioural model on every clock.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    MAP_HIGH = 1'b0,
    MAP_LOW  = 1'b1
  } map_mode_e;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
  parameter int SEL_W = 4,
  parameter int OFF_W = 11,
  parameter ilv_pkg::map_mode_e MODE = ilv_pkg::MAP_HIGH,
  localparam int ADDR_W = SEL_W + OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  off
);
  generate
    if (MODE == ilv_pkg::MAP_HIGH) begin : g_high
      assign sel = addr[ADDR_W-1:OFF_W];
      assign off = addr[OFF_W-1:0];
    end else begin : g_low
      assign sel = addr[SEL_W-1:0];
      assign off = addr[ADDR_W-1:SEL_W];
    end
  endgenerate
endmodule

// File: rtl/ilv_bank_decode.sv
module ilv_bank_decode #(
  parameter int BANKS = 16,
  localparam int SEL_W = $clog2(BANKS)
) (
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  output logic [BANKS-1:0] onehot
);
  for (genvar b = 0; b < BANKS; b++) begin : g_dec
    assign onehot[b] = enable && (sel == SEL_W'(b));
  end
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) cells[off] <= wdata;
      else    rdata      <= cells[off];
    end
  end
endmodule

// File: rtl/ilv_bank_mem.sv
module ilv_bank_mem #(
  parameter int BANKS      = 16,
  parameter int BANK_DEPTH = 2048,
  parameter int DATA_W     = 8,
  parameter ilv_pkg::map_mode_e MODE = ilv_pkg::MAP_HIGH,
  localparam int SEL_W  = $clog2(BANKS),
  localparam int OFF_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = SEL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [BANKS-1:0]  bank_en,
  output logic [OFF_W-1:0]  bank_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [SEL_W-1:0]  sel;
  logic [SEL_W-1:0]  sel_q;
  logic              accept;
  logic [DATA_W-1:0] bank_rd [BANKS];

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  ilv_addr_split #(.SEL_W(SEL_W), .OFF_W(OFF_W), .MODE(MODE)) u_split (
    .addr (req_addr),
    .sel  (sel),
    .off  (bank_offset)
  );

  ilv_bank_decode #(.BANKS(BANKS)) u_dec (
    .enable (accept),
    .sel    (sel),
    .onehot (bank_en)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ilv_bank_ram #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .ce    (bank_en[b]),
      .we    (req_write),
      .off   (bank_offset),
      .wdata (req_wdata),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      sel_q     <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      sel_q     <= sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_rdata = bank_rd[sel_q];

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  assert_enable_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (bank_en != '0));
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (bank_en == '0 && !req_ready));
  assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
endmodule

// File: tb/ilv_bank_mem_bench.sv
module ilv_bank_mem_bench;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;

  logic rdy_h, rv_h, rdy_l, rv_l;
  logic [15:0] en_h, en_l;
  logic [10:0] off_h, off_l;
  logic [7:0] rd_h, rd_l;

  int checks = 0;
  int failures = 0;

  logic [7:0] model_mem [int];
  bit exp_rv = 0;
  bit exp_known = 0;
  logic [7:0] exp_rd = '0;

  always #4 clk = ~clk;

  ilv_bank_mem u_ilv_bank_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_h),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_en(en_h), .bank_offset(off_h), .rsp_valid(rv_h),
    .rsp_ready(rsp_ready), .rsp_rdata(rd_h));

  ilv_bank_mem #(.MODE(ilv_pkg::MAP_LOW)) u_ilv_bank_mem_lo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_l),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_en(en_l), .bank_offset(off_l), .rsp_valid(rv_l),
    .rsp_ready(rsp_ready), .rsp_rdata(rd_l));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int bank_of(input bit low, input int a);
    return low ? (a & 15) : (a >> 11);
  endfunction

  function automatic int off_of(input bit low, input int a);
    return low ? (a >> 4) : (a & 2047);
  endfunction

  // compare one instance with the model in the middle of a cycle
  task automatic compare(input bit low, input logic [15:0] en, input logic [10:0] off,
                         input logic rdy, input logic rv, input logic [7:0] rd);
    bit exp_ready;
    int exp_en;
    string tag_map;
    tag_map = low ? "R3 split" : "R2 split";
    exp_ready = !exp_rv || rsp_ready;
    exp_en = (req_valid && exp_ready) ? (1 << bank_of(low, int'(req_addr))) : 0;
    chk(rdy == exp_ready, "R7 req_ready", int'(rdy), int'(exp_ready));
    chk(int'(en) == exp_en, "R4 bank_en", int'(en), exp_en);
    if (req_valid)
      chk(int'(off) == off_of(low, int'(req_addr)), tag_map, int'(off),
          off_of(low, int'(req_addr)));
    chk(rv == exp_rv, "R6 rsp_valid", int'(rv), int'(exp_rv));
    if (exp_rv && exp_known)
      chk(rd == exp_rd, "R6 rsp_rdata", int'(rd), int'(exp_rd));
  endtask

  task automatic cyc(input bit v, input bit w, input int a, input int d, input bit rr);
    bit acc;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = 8'(d); rsp_ready = rr;
    #1;
    compare(1'b0, en_h, off_h, rdy_h, rv_h, rd_h);
    compare(1'b1, en_l, off_l, rdy_l, rv_l, rd_l);
    @(posedge clk);
    acc = v && (!exp_rv || rr);
    if (acc && w) begin
      model_mem[a] = 8'(d);
      exp_rv = 0;
    end else if (acc) begin
      exp_rv = 1;
      exp_known = model_mem.exists(a);
      if (exp_known) exp_rd = model_mem[a];
    end else if (rr) begin
      exp_rv = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prev_h, prev_l;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rv_h == 1'b0 && rv_l == 1'b0, "R1 rsp_valid", int'(rv_h | rv_l), 0);
    chk(en_h == '0 && en_l == '0, "R1 bank_en", int'(en_h | en_l), 0);
    cyc(0, 0, 0, 0, 1);

    // R5: same offset, all banks, both mappings
    for (int k = 0; k < 16; k++) cyc(1, 1, k * 2048 + 5, 8'h40 + k, 1);
    for (int k = 0; k < 16; k++) cyc(1, 1, k + 16 * 9, 8'h80 + k, 1);
    for (int k = 0; k < 16; k++) cyc(1, 0, k * 2048 + 5, 0, 1);
    for (int k = 0; k < 16; k++) cyc(1, 0, k + 16 * 9, 0, 1);
    cyc(0, 0, 0, 0, 1);

    // R8: consecutive addresses
    for (int a = 100; a < 132; a++) cyc(1, 1, a, a ^ 8'h5a, 1);
    prev_h = -1; prev_l = -1;
    for (int a = 100; a < 132; a++) begin
      cyc(1, 0, a, 0, 1);
      if (prev_h >= 0) begin
        chk(int'(en_h) == prev_h, "R8 high same bank", int'(en_h), prev_h);
        chk(int'(en_l) != prev_l, "R8 low new bank", int'(en_l), prev_l);
      end
      prev_h = int'(en_h); prev_l = int'(en_l);
    end
    cyc(0, 0, 0, 0, 1);

    // R10 endpoints
    cyc(1, 1, 0, 8'h11, 1);
    cyc(1, 1, 32'h7fff, 8'hee, 1);
    cyc(1, 0, 0, 0, 1);
    cyc(1, 0, 32'h7fff, 0, 1);
    #1;
    chk(en_h == 16'h8000 && en_l == 16'h8000, "R10 top bank", int'(en_h), 32'h8000);
    chk(off_h == 11'h7ff && off_l == 11'h7ff, "R10 top offset", int'(off_l), 32'h7ff);
    cyc(0, 0, 0, 0, 1);
    #1;
    chk(rd_h == 8'hee && rd_l == 8'hee, "R10 top data", int'(rd_h), 32'hee);

    // R7 back-pressure with changing requests
    cyc(1, 0, 100, 0, 0);
    cyc(1, 1, 200, 8'h33, 0);
    cyc(1, 0, 5, 0, 0);
    cyc(1, 1, 9000, 8'h44, 0);
    #1;
    chk(rd_h == (8'(100) ^ 8'h5a), "R7 held data", int'(rd_h), int'(8'(100) ^ 8'h5a));
    cyc(1, 0, 2048 + 5, 0, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);

    // R9 write after read with ready low then high
    cyc(1, 1, 300, 8'h77, 1);
    cyc(0, 0, 0, 0, 1);
    #1;
    chk(rv_h == 1'b0 && rv_l == 1'b0, "R9 no response", int'(rv_h), 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int a;
      a = int'($urandom_range(0, 63)) * 509 & 32'h7fff;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
          int'($urandom_range(0, 255)), $urandom_range(0, 3) != 0);
    end
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule